// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external controller read and write an internal register bank over a four-wire serial link: serial clock, active-low chip select, serial data in and serial data out. The link signals are oversampled by the system clock, so the block runs entirely in one clock domain. That system clock must be at least four times the serial clock rate.

A transfer starts when chip select goes low. The first eight bits form a command byte:

- Bit 7 selects a write (1) or a read (0).
- Bits 6 and 5 are reserved and must be zero.
- Bits 4 to 0 give the register address.

One to three data bytes follow. Their number depends on the addressed register and comes from a per-address length table. Data travels most significant byte first, and each byte is sent most significant bit first.

Timing on the link is as follows:

- The slave samples serial input on falling serial-clock edges.
- The slave changes its serial output after rising edges.
- The output enable drops when chip select rises, and also once the last data bit of a read has been clocked.

Toward the bank, the block offers a simple register-bus port: an address, right-justified write data, a one-cycle write strobe, a one-cycle read strobe, and read data. The read data must be valid combinationally in the cycle of the read strobe. The bank itself lies outside the block.

Top module: `serreg_slave`

## Requirements
- R1: A command byte is decoded as {write flag in bit 7, reserved bits 6:5, address in bits 4:0}. A command whose reserved bits are not both zero is ignored until chip select rises: it produces no strobe and never enables the output.
- R2: The number of data bytes for address a is taken from the 2-bit code at bits [2a+1:2a] of the length-table parameter. Code 0 means one byte. With the default table, addresses with a mod 4 = 0, 1, 2, 3 carry 1, 2, 3 and 3 bytes.
- R3: Data-in bits are captured on falling serial-clock edges, most significant byte first and most significant bit first. The written value appears right-justified on the write-data port, with the unused upper bits set to zero.
- R4: A write raises the write strobe for exactly one cycle after the last data bit of the register, with the address and data held stable. Further bits before chip select rises are ignored.
- R5: If chip select rises before the last data bit of a write, no write strobe occurs.
- R6: A read raises the read strobe for one cycle with the address as soon as the command byte completes. The value present in that cycle is what gets shifted out, even if the bank changes later in the transfer.
- R7: Read data changes only after rising serial-clock edges. The first data bit, which is the most significant bit of the top byte, is presented after the rising edge that follows the command byte.
- R8: The output enable is low whenever synchronized chip select is high, and it drops after the last falling edge of a read even while chip select is still low.
- R9: Chip select going high at any point, including in the middle of a command byte, returns the slave to waiting for a command byte. The next transfer then works normally.
- R10: A falling serial-clock edge that is synchronized in the same cycle as the rising edge of chip select still counts as a data bit and can complete a write.
- R11: After reset, both strobes are low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the controller (idles high) |
| csn_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data from the controller |
| sdo_o | output | 1 | Serial data to the controller |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means the line floats |
| rb_addr_o | output | 5 | Register address toward the bank |
| rb_wdata_o | output | 24 | Right-justified write data |
| rb_wr_o | output | 1 | One-cycle write strobe |
| rb_rd_o | output | 1 | One-cycle read strobe; rb_rdata_i is captured in this cycle |
| rb_rdata_i | input | 24 | Read data from the bank for rb_addr_o |

## Verification
The two functions that can land in the same cycle are the final falling serial-clock edge of a write and the return to the idle state when chip select rises. The bench provokes this by releasing chip select at the same instant as the last falling clock edge, so both pass through the synchronizer together. It judges the outcome by requiring exactly one write strobe carrying the full value. A neighbouring case checks that releasing chip select one bit earlier produces no strobe and leaves the bank's old value readable.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    localparam int CMD_W     = 8;
    localparam int ADDR_W    = 5;
    localparam int RSV_W     = CMD_W - 1 - ADDR_W;
    localparam int MAX_BYTES = 3;
    localparam int DATA_W    = 8 * MAX_BYTES;
    localparam int LEN_W     = $clog2(MAX_BYTES + 1);
    localparam int CNT_W     = $clog2(DATA_W + 1);
    localparam int NREG      = 1 << ADDR_W;

    // default length codes: address mod 4 -> 1, 2, 3, 3 bytes
    localparam logic [NREG*LEN_W-1:0] LEN_TABLE_DEF = {(NREG / 4){8'hF9}};

    typedef enum logic [1:0] {
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_END
    } xfer_state_e;

    typedef struct packed {
        logic              is_write;
        logic [RSV_W-1:0]  rsvd;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] code);
        if (code == '0)
            return LEN_W'(1);
        else if (int'(code) > MAX_BYTES)
            return LEN_W'(MAX_BYTES);
        else
            return code;
    endfunction

endpackage

// File: rtl/serreg_frontend.sv
module serreg_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic sdi_i,
    output logic sclk_fall,
    output logic sclk_rise,
    output logic csn_s,
    output logic cs_live,
    output logic sdi_s
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b011; // {sdi, csn, sclk}

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic [SYNC_STAGES-1:0] chain [NSIG];
    logic sclk_d;
    logic csn_d;

    assign raw = {sdi_i, csn_i, sclk_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)
                chain[g] <= {SYNC_STAGES{RST_VAL[g]}};
            else if (SYNC_STAGES > 1)
                chain[g] <= {chain[g][SYNC_STAGES-2:0], raw[g]};
            else
                chain[g] <= raw[g];
        end
        assign synced[g] = chain[g][SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b1;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= synced[0];
            csn_d  <= synced[1];
        end
    end

    assign sclk_fall = sclk_d & ~synced[0];
    assign sclk_rise = ~sclk_d & synced[0];
    assign csn_s     = synced[1];
    assign cs_live   = ~(synced[1] & csn_d);
    assign sdi_s     = synced[2];

endmodule

// File: rtl/serreg_ctrl.sv
module serreg_ctrl
    import serreg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int LW = LEN_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk_fall,
    input  logic          csn_s,
    input  logic          cs_live,
    input  logic          sdi_s,
    output logic [AW-1:0] lookup_addr,
    input  logic [LW-1:0] lookup_len,
    output logic [AW-1:0] rb_addr_o,
    output logic [DW-1:0] rb_wdata_o,
    output logic          rb_wr_o,
    output logic          rb_rd_o,
    output logic [LW-1:0] len_q,
    output logic          rd_active
);
    xfer_state_e   state;
    logic [6:0]    cmd_sh;
    logic [2:0]    bit_cnt;
    logic [CW-1:0] data_cnt;
    logic [CW-1:0] tgt_bits;
    logic [DW-1:0] wacc;
    cmd_t          cmd_now;
    logic          take;
    logic          last_data;

    always_comb begin
        cmd_now     = cmd_t'({cmd_sh, sdi_s});
        lookup_addr = cmd_now.addr;
        take        = sclk_fall & cs_live;
        last_data   = (data_cnt == tgt_bits - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_CMD;
            cmd_sh     <= '0;
            bit_cnt    <= '0;
            data_cnt   <= '0;
            tgt_bits   <= '0;
            wacc       <= '0;
            len_q      <= '0;
            rb_addr_o  <= '0;
            rb_wdata_o <= '0;
            rb_wr_o    <= 1'b0;
            rb_rd_o    <= 1'b0;
        end else begin
            rb_wr_o <= 1'b0;
            rb_rd_o <= 1'b0;
            if (take) begin
                case (state)
                    ST_CMD: begin
                        cmd_sh  <= cmd_now[6:0];
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            if (cmd_now.rsvd != '0) begin
                                state <= ST_END;
                            end else begin
                                rb_addr_o <= cmd_now.addr;
                                len_q     <= lookup_len;
                                tgt_bits  <= CW'(lookup_len) << 3;
                                data_cnt  <= '0;
                                wacc      <= '0;
                                if (cmd_now.is_write) begin
                                    state <= ST_WR;
                                end else begin
                                    state   <= ST_RD;
                                    rb_rd_o <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_WR: begin
                        wacc     <= {wacc[DW-2:0], sdi_s};
                        data_cnt <= data_cnt + CW'(1);
                        if (last_data) begin
                            rb_wdata_o <= {wacc[DW-2:0], sdi_s};
                            rb_wr_o    <= 1'b1;
                            state      <= ST_END;
                        end
                    end
                    ST_RD: begin
                        data_cnt <= data_cnt + CW'(1);
                        if (last_data)
                            state <= ST_END;
                    end
                    default: ;
                endcase
            end
            if (csn_s) begin
                state    <= ST_CMD;
                bit_cnt  <= '0;
                data_cnt <= '0;
            end
        end
    end

    assign rd_active = (state == ST_RD);

endmodule

// File: rtl/serreg_tx.sv
module serreg_tx
    import serreg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] rdata,
    input  logic [LW-1:0] len_q,
    input  logic          sclk_rise,
    input  logic          rd_active,
    input  logic          csn_s,
    output logic          sdo_o,
    output logic          sdo_oe_o
);
    logic [DW-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            sdo_o    <= 1'b0;
            sdo_oe_o <= 1'b0;
        end else begin
            if (load)
                sh <= rdata << (DW - 8 * int'(len_q));
            if (csn_s || !rd_active) begin
                sdo_oe_o <= 1'b0;
            end else if (sclk_rise) begin
                sdo_o    <= sh[DW-1];
                sh       <= sh << 1;
                sdo_oe_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
    import serreg_pkg::*;
#(
    parameter int                      SYNC_STAGES = 2,
    parameter logic [NREG*LEN_W-1:0]   LEN_TABLE   = LEN_TABLE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [ADDR_W-1:0] rb_addr_o,
    output logic [DATA_W-1:0] rb_wdata_o,
    output logic              rb_wr_o,
    output logic              rb_rd_o,
    input  logic [DATA_W-1:0] rb_rdata_i
);
    logic              sclk_fall;
    logic              sclk_rise;
    logic              csn_s;
    logic              cs_live;
    logic              sdi_s;
    logic [ADDR_W-1:0] lookup_addr;
    logic [LEN_W-1:0]  lookup_len;
    logic [LEN_W-1:0]  len_q;
    logic              rd_active;

    assign lookup_len = eff_len(LEN_TABLE[int'(lookup_addr) * LEN_W +: LEN_W]);

    serreg_frontend #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_front (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (sclk_i),
        .csn_i     (csn_i),
        .sdi_i     (sdi_i),
        .sclk_fall (sclk_fall),
        .sclk_rise (sclk_rise),
        .csn_s     (csn_s),
        .cs_live   (cs_live),
        .sdi_s     (sdi_s)
    );

    serreg_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .sclk_fall   (sclk_fall),
        .csn_s       (csn_s),
        .cs_live     (cs_live),
        .sdi_s       (sdi_s),
        .lookup_addr (lookup_addr),
        .lookup_len  (lookup_len),
        .rb_addr_o   (rb_addr_o),
        .rb_wdata_o  (rb_wdata_o),
        .rb_wr_o     (rb_wr_o),
        .rb_rd_o     (rb_rd_o),
        .len_q       (len_q),
        .rd_active   (rd_active)
    );

    serreg_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (rb_rd_o),
        .rdata     (rb_rdata_i),
        .len_q     (len_q),
        .sclk_rise (sclk_rise),
        .rd_active (rd_active),
        .csn_s     (csn_s),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o)
    );

endmodule

// File: rtl/serreg_chk.sv
module serreg_chk
    import serreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              csn_s,
    input logic              sclk_rise,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input logic              rb_wr_o,
    input logic              rb_rd_o,
    input logic [ADDR_W-1:0] rb_addr_o
);
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rb_wr_o |=> !rb_wr_o); // R4

    AST_WR_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        rb_wr_o |-> $stable(rb_addr_o)); // R4

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rb_rd_o |=> !rb_rd_o); // R6

    AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rb_wr_o && rb_rd_o)); // R1

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> !sdo_oe_o); // R8

    AST_SDO_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe_o && $past(sdo_oe_o) && !$stable(sdo_o)) |-> $past(sclk_rise)); // R7

endmodule

bind serreg_slave serreg_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .csn_s     (csn_s),
    .sclk_rise (sclk_rise),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o),
    .rb_wr_o   (rb_wr_o),
    .rb_rd_o   (rb_rd_o),
    .rb_addr_o (rb_addr_o)
);

// File: tb/test_serreg_slave.sv
module test_serreg_slave;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1;
    logic csn = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, rb_wr, rb_rd;
    logic [4:0]  rb_addr;
    logic [23:0] rb_wdata, rb_rdata;
    logic [23:0] bank [32];
    logic [23:0] expv [32];
    int n_chk = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0, cycles = 0;
    logic [4:0]  last_waddr = '0, last_raddr = '0;
    logic [23:0] last_wdata = '0;
    logic oe_seen = 1'b0;
    bit done = 1'b0;

    // vector: {write flag, address, data}
    localparam logic [29:0] VEC [11] = '{
        {1'b1, 5'd0,  24'h0000A5},
        {1'b1, 5'd1,  24'h00C33C},
        {1'b1, 5'd2,  24'h8001FF},
        {1'b1, 5'd7,  24'hFFFFFF},
        {1'b1, 5'd13, 24'h123456},
        {1'b0, 5'd0,  24'h000000},
        {1'b0, 5'd1,  24'h000000},
        {1'b0, 5'd2,  24'h000000},
        {1'b0, 5'd7,  24'h000000},
        {1'b0, 5'd13, 24'h000000},
        {1'b0, 5'd30, 24'h000000}
    };

    always #2 clk = ~clk;

    serreg_slave i_serreg_slave (
        .clk        (clk),
        .rst        (rst),
        .sclk_i     (sclk),
        .csn_i      (csn),
        .sdi_i      (sdi),
        .sdo_o      (sdo),
        .sdo_oe_o   (sdo_oe),
        .rb_addr_o  (rb_addr),
        .rb_wdata_o (rb_wdata),
        .rb_wr_o    (rb_wr),
        .rb_rd_o    (rb_rd),
        .rb_rdata_i (rb_rdata)
    );

    assign rb_rdata = bank[rb_addr];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rb_wr) begin
            wr_cnt     <= wr_cnt + 1;
            last_waddr <= rb_addr;
            last_wdata <= rb_wdata;
            bank[rb_addr] <= rb_wdata;
        end
        if (rb_rd) begin
            rd_cnt     <= rd_cnt + 1;
            last_raddr <= rb_addr;
        end
        if (sdo_oe)
            oe_seen <= 1'b1;
    end

    function automatic int blen(input logic [4:0] a);
        case (a[1:0])
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [23:0] bmask(input int n);
        return 24'hFFFFFF >> (8 * (3 - n));
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one transfer; cut >= 0 stops after that many bits, mod_bit flips the
    // addressed bank word just before that bit's falling edge
    task automatic xfer(input logic [7:0] cmd, input int nb, input logic [23:0] wd,
                        input int cut, input bit cs_last, input int mod_bit,
                        output logic [23:0] rd, output logic oe_end);
        logic [31:0] stream;
        int total;
        stream = {cmd, wd << (8 * (3 - nb))};
        total = 8 + 8 * nb;
        if (cut >= 0 && cut < total)
            total = cut;
        rd = '0;
        @(negedge clk) csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < total; i++) begin
            sdi = stream[31 - i];
            repeat (8) @(negedge clk);
            if (i >= 8)
                rd = {rd[22:0], sdo};
            if (i == mod_bit)
                bank[cmd[4:0]] = ~bank[cmd[4:0]];
            sclk = 1'b0;
            if (cs_last && i == total - 1)
                csn = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (8) @(negedge clk);
        oe_end = sdo_oe;
        csn = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < 32; a++) begin
            bank[a] = (24'(a) * 24'h0B1357) ^ 24'h2468AC;
            expv[a] = bank[a];
        end
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected 0", cycles);
            report();
        end
    end

    initial begin
        logic [23:0] rdv;
        logic oe_e;
        int wc0, rc0;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11", "oe after reset", 24'(sdo_oe), 24'h0);
        chk("R11", "write strobe after reset", 24'(rb_wr), 24'h0);
        chk("R11", "read strobe after reset", 24'(rb_rd), 24'h0);

        for (int v = 0; v < 11; v++) begin
            logic w;
            logic [4:0] a;
            logic [23:0] d, e;
            int l, wcv, rcv;
            {w, a, d} = VEC[v];
            l = blen(a);
            wcv = wr_cnt;
            rcv = rd_cnt;
            xfer({w, 2'b00, a}, l, d, -1, 1'b0, -1, rdv, oe_e);
            if (w) begin
                e = d & bmask(l);
                expv[a] = e;
                chk("R4", "one write strobe", 24'(wr_cnt - wcv), 24'd1);
                chk("R4", "write address", 24'(last_waddr), 24'(a));
                chk("R2 R3", "write data", last_wdata, e);
            end else begin
                chk("R6", "one read strobe", 24'(rd_cnt - rcv), 24'd1);
                chk("R6", "read address", 24'(last_raddr), 24'(a));
                chk("R7 R2", "read data", rdv, expv[a] & bmask(l));
                chk("R8", "oe after last read bit", 24'(oe_e), 24'h0);
            end
        end

        // R9: chip select rises inside a command byte, then a normal read
        wc0 = wr_cnt;
        xfer(8'h81, 2, 24'h00FFFF, 5, 1'b0, -1, rdv, oe_e);
        xfer(8'h01, 2, 24'h0, -1, 1'b0, -1, rdv, oe_e);
        chk("R9", "read after aborted command", rdv, expv[1]);
        chk("R9", "no write from aborted command", 24'(wr_cnt - wc0), 24'd0);

        // R5: chip select rises one bit before the end of a write
        wc0 = wr_cnt;
        xfer(8'h82, 3, 24'h777777, 31, 1'b0, -1, rdv, oe_e);
        chk("R5", "no strobe on short write", 24'(wr_cnt - wc0), 24'd0);
        xfer(8'h02, 3, 24'h0, -1, 1'b0, -1, rdv, oe_e);
        chk("R5", "register kept after short write", rdv, expv[2]);

        // R1: nonzero reserved bits on a write and on a read
        wc0 = wr_cnt;
        rc0 = rd_cnt;
        @(negedge clk) oe_seen = 1'b0;
        xfer(8'hA3, 3, 24'h111111, -1, 1'b0, -1, rdv, oe_e);
        xfer(8'h63, 3, 24'h0, -1, 1'b0, -1, rdv, oe_e);
        chk("R1", "no write on reserved bits", 24'(wr_cnt - wc0), 24'd0);
        chk("R1", "no read on reserved bits", 24'(rd_cnt - rc0), 24'd0);
        chk("R1", "output never enabled", 24'(oe_seen), 24'd0);

        // R10: last falling edge and chip select release together
        wc0 = wr_cnt;
        xfer(8'h84, 1, 24'h00005C, -1, 1'b1, -1, rdv, oe_e);
        chk("R10", "write with simultaneous release", 24'(wr_cnt - wc0), 24'd1);
        chk("R10", "data with simultaneous release", last_wdata, 24'h00005C);
        expv[4] = 24'h00005C;

        // R4: extra byte after a one-byte register is ignored
        wc0 = wr_cnt;
        xfer(8'h80, 2, 24'h00E718, -1, 1'b0, -1, rdv, oe_e);
        chk("R4", "single strobe with trailing byte", 24'(wr_cnt - wc0), 24'd1);
        chk("R4", "trailing byte ignored", last_wdata, 24'h0000E7);
        expv[0] = 24'h0000E7;

        // R8: output released once chip select is high
        chk("R8", "oe with chip select high", 24'(sdo_oe), 24'h0);

        // R6: bank changes during a read do not disturb the shifted value
        xfer(8'h02, 3, 24'h0, -1, 1'b0, 12, rdv, oe_e);
        chk("R6", "read value latched at command", rdv, expv[2]);
        xfer(8'h02, 3, 24'h0, -1, 1'b0, -1, rdv, oe_e);
        chk("R6", "new value on next read", rdv, ~expv[2]);

        done = 1'b1;
        report();
    end

endmodule